// File: doc/BRIEF.md
# Indirect Configuration Register Window

This block is a small host I/O slave. It gives access to two banks of seven configuration registers, one bank per disk channel, through only two byte addresses. The host first writes a pointer byte at offset 1. That byte selects a channel bank and a register index, and it also carries four global option bits. The host then reads or writes the chosen register through a 16-bit data port at offset 0. When the auto-increment option is set, the index steps forward after each data-port access, so a full bank can be swept with back-to-back data accesses.

Each bank holds:
- a word-wide command-block base register;
- a general configuration byte;
- a 10-bit read-ahead count split over two write-only registers;
- a word-wide control-block base register;
- two timing bytes.

Every register comes out of reset with a fixed default. The read-ahead settings and the general configuration byte leave the block as ports, for use by logic further along. Writing the FIFO-clear bit produces a one-cycle strobe for the channel whose bank was written. Read data is registered. It appears in the cycle after the read request and then holds until the next read.

Inputs are decoded each cycle into an access kind:
- `ACC_NONE`: no access;
- `ACC_PTR_WR`: pointer write;
- `ACC_PTR_RD`: pointer read;
- `ACC_DATA_WR`: data-port write;
- `ACC_DATA_RD`: data-port read;
- `ACC_VOID_RD`: read of an unused offset.

A write request wins when `wr_en` and `rd_en` are both high. Each bank has a strobe state machine with two states, `FC_IDLE` and `FC_PULSE`, and two transitions:
- `FC_IDLE` moves to `FC_PULSE` on a data write to index 3 of that bank with bit 6 set.
- `FC_PULSE` moves back to `FC_IDLE` on the next cycle, unless another such write arrives in that cycle.

Top module: `cfgwin_top`

## Requirements
- R1: After reset the registers hold these values:
  - pointer: 0x50 (channel 0, index 0);
  - index 0: 0x01F0 (channel 0) and 0x0170 (channel 1);
  - index 1: 0x01;
  - index 4: 0x03F6 and 0x0376;
  - index 5: 0xF5;
  - index 6: 0xDE;
  - read-ahead count 0, read-ahead enable 0;
  - `rdata` 0, no strobe.
- R2: Pointer layout: bits 2:0 are the register index and bit 3 the channel (0 or 1). A data-port access reaches only the register selected by that pointer, and the two banks hold separate values.
- R3: With pointer bit 7 set, each data-port read or write advances the index by one, and the step after index 6 (or 7) goes to 0. With bit 7 clear the pointer does not change on data accesses.
- R4: Indices 2 and 3 are write-only and read as 0. `ra_count_o` is {index 3 bits 1:0, index 2 bits 7:0}. `ra_enable_o` is index 3 bit 7.
- R5: A data write to index 3 with bit 6 set raises `fifo_clear_o` for that channel for exactly one cycle, starting in the cycle after the write. The bit is not kept in any register.
- R6: Indices 0 and 4 store and return all 16 bits. Indices 1, 5 and 6 store the low byte only and read back with a zero high byte. `gen_cfg_o` shows index 1.
- R7: Index 7 reads as 0, and writes to it change nothing.
- R8: Reading offset 1 returns the pointer with bit 5 (burst disable, write-only) forced to 0 and the upper byte 0. All other pointer bits read back as written.
- R9: `rdata` is loaded in the cycle after a read request and holds while no read occurs. Reads of offsets 2 and 3 return 0, and writes to them change nothing.
- R10: When `wr_en` and `rd_en` are both high, only the write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Byte offset: 0 data port, 1 pointer |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wdata | input | 16 | Write data (pointer uses bits 7:0) |
| rdata | output | 16 | Registered read data |
| gen_cfg_o | output | 2x8 | General configuration byte per channel |
| ra_count_o | output | 2x10 | Read-ahead count per channel |
| ra_enable_o | output | 2 | Read-ahead enable per channel |
| fifo_clear_o | output | 2 | One-cycle FIFO clear strobe per channel |

## Verification
The assertions check, on every cycle, the following:
- the wrap of the index from 6 to 0 under auto-increment;
- the stillness of the pointer when auto-increment is off;
- the zero values returned for write-only registers and index 7;
- the clear high byte on byte registers;
- the hidden pointer bit 5;
- the hold of `rdata` between reads;
- that each strobe follows a matching write.

Only the bench's scenarios can show the actual reset values, that a written value lands in the correct channel bank, the assembly of the 10-bit read-ahead count, the exact length of the strobe, and write priority over a simultaneous read.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int DW    = 16;
    localparam int IDX_W = 3;
    localparam int RA_W  = 10;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_PTR_WR,
        ACC_PTR_RD,
        ACC_DATA_WR,
        ACC_DATA_RD,
        ACC_VOID_RD
    } acc_t;

    typedef enum logic {
        FC_IDLE,
        FC_PULSE
    } fc_state_t;

    typedef struct packed {
        logic             auto_inc;
        logic             post_wait;
        logic             burst_off;
        logic             devsel_med;
        logic             chan;
        logic [IDX_W-1:0] idx;
    } ptr_t;

    localparam logic [7:0] PTR_RESET = 8'h50;
    localparam logic [7:0] PTR_WO_MASK = 8'hDF;

    function automatic logic [DW-1:0] cmd_base_rst(input int ch);
        return (ch == 0) ? 16'h01F0 : 16'h0170;
    endfunction

    function automatic logic [DW-1:0] ctl_base_rst(input int ch);
        return (ch == 0) ? 16'h03F6 : 16'h0376;
    endfunction

endpackage

// File: rtl/cfgwin_ptr.sv
module cfgwin_ptr
    import cfgwin_pkg::*;
#(
    parameter int IDX_LAST = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  acc_t       acc,
    input  logic [7:0] wbyte,
    output ptr_t       ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(IDX_LAST);

    logic data_acc;
    assign data_acc = (acc == ACC_DATA_WR) || (acc == ACC_DATA_RD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= ptr_t'(PTR_RESET);
        end else if (acc == ACC_PTR_WR) begin
            ptr <= ptr_t'(wbyte);
        end else if (data_acc && ptr.auto_inc) begin
            ptr.idx <= (ptr.idx >= LAST) ? '0 : ptr.idx + 1'b1;
        end
    end
endmodule

// File: rtl/cfgwin_bank.sv
module cfgwin_bank
    import cfgwin_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_val,
    output logic [7:0]       gen_cfg,
    output logic [RA_W-1:0]  ra_count,
    output logic             ra_enable,
    output logic             fifo_clear
);
    logic [DW-1:0] cmd_base, ctl_base;
    logic [7:0]    ra_lo, ra_cfg, tim_data, tim_cmd;
    fc_state_t     fc_state, fc_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_base <= cmd_base_rst(CH);
            gen_cfg  <= 8'h01;
            ra_lo    <= 8'h00;
            ra_cfg   <= 8'h00;
            ctl_base <= ctl_base_rst(CH);
            tim_data <= 8'hF5;
            tim_cmd  <= 8'hDE;
        end else if (wr) begin
            unique case (idx)
                3'd0: cmd_base <= wdata;
                3'd1: gen_cfg  <= wdata[7:0];
                3'd2: ra_lo    <= wdata[7:0];
                3'd3: ra_cfg   <= wdata[7:0] & 8'hBF;
                3'd4: ctl_base <= wdata;
                3'd5: tim_data <= wdata[7:0];
                3'd6: tim_cmd  <= wdata[7:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            3'd0:    rd_val = cmd_base;
            3'd1:    rd_val = {8'h00, gen_cfg};
            3'd4:    rd_val = ctl_base;
            3'd5:    rd_val = {8'h00, tim_data};
            3'd6:    rd_val = {8'h00, tim_cmd};
            default: rd_val = '0;
        endcase
    end

    assign ra_count  = {ra_cfg[1:0], ra_lo};
    assign ra_enable = ra_cfg[7];

    always_ff @(posedge clk) begin
        if (!rst_n) fc_state <= FC_IDLE;
        else        fc_state <= fc_next;
    end

    always_comb begin
        unique case (fc_state)
            FC_IDLE, FC_PULSE:
                fc_next = (wr && idx == 3'd3 && wdata[6]) ? FC_PULSE : FC_IDLE;
            default: fc_next = FC_IDLE;
        endcase
    end

    assign fifo_clear = (fc_state == FC_PULSE);
endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
    import cfgwin_pkg::*;
#(
    parameter int IDX_LAST = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [15:0]         wdata,
    output logic [15:0]         rdata,
    output logic [1:0][7:0]     gen_cfg_o,
    output logic [1:0][9:0]     ra_count_o,
    output logic [1:0]          ra_enable_o,
    output logic [1:0]          fifo_clear_o
);
    localparam int NUM_CH = 2;

    acc_t              acc;
    ptr_t              ptr;
    logic [7:0]        ptr_q;
    logic [DW-1:0]     bank_rd [NUM_CH];

    always_comb begin
        acc = ACC_NONE;
        if (wr_en) begin
            unique case (addr)
                2'd0:    acc = ACC_DATA_WR;
                2'd1:    acc = ACC_PTR_WR;
                default: acc = ACC_NONE;
            endcase
        end else if (rd_en) begin
            unique case (addr)
                2'd0:    acc = ACC_DATA_RD;
                2'd1:    acc = ACC_PTR_RD;
                default: acc = ACC_VOID_RD;
            endcase
        end
    end

    cfgwin_ptr #(.IDX_LAST(IDX_LAST)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .wbyte (wdata[7:0]),
        .ptr   (ptr)
    );
    assign ptr_q = ptr;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
        cfgwin_bank #(.CH(c)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (acc == ACC_DATA_WR && int'(ptr.chan) == c),
            .idx        (ptr.idx),
            .wdata      (wdata),
            .rd_val     (bank_rd[c]),
            .gen_cfg    (gen_cfg_o[c]),
            .ra_count   (ra_count_o[c]),
            .ra_enable  (ra_enable_o[c]),
            .fifo_clear (fifo_clear_o[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            unique case (acc)
                ACC_DATA_RD: rdata <= bank_rd[ptr.chan];
                ACC_PTR_RD:  rdata <= {8'h00, ptr_q & PTR_WO_MASK};
                ACC_VOID_RD: rdata <= '0;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/cfgwin_checker.sv
module cfgwin_checker
    import cfgwin_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input acc_t            acc,
    input logic [7:0]      ptr_q,
    input logic [15:0]     wdata,
    input logic [15:0]     rdata,
    input logic [1:0]      fifo_clear_o
);
    logic data_acc;
    assign data_acc = (acc == ACC_DATA_WR) || (acc == ACC_DATA_RD);

    assert_idx_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && ptr_q[7] && ptr_q[2:0] == 3'd6) |=> (ptr_q[2:0] == 3'd0));

    assert_ptr_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !ptr_q[7]) |=> $stable(ptr_q));

    assert_wo_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_DATA_RD && (ptr_q[2:0] == 3'd2 || ptr_q[2:0] == 3'd3)) |=> (rdata == 16'h0));

    assert_idx7_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_DATA_RD && ptr_q[2:0] == 3'd7) |=> (rdata == 16'h0));

    assert_byte_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_DATA_RD && (ptr_q[2:0] == 3'd1 || ptr_q[2:0] == 3'd5 || ptr_q[2:0] == 3'd6))
        |=> (rdata[15:8] == 8'h00));

    assert_ptr_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_PTR_RD) |=> (rdata[5] == 1'b0));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_NONE || acc == ACC_DATA_WR || acc == ACC_PTR_WR) |=> $stable(rdata));

    assert_strobe_ch0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear_o[0] |-> $past(acc == ACC_DATA_WR && ptr_q[3:0] == 4'h3 && wdata[6]));

    assert_strobe_ch1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear_o[1] |-> $past(acc == ACC_DATA_WR && ptr_q[3:0] == 4'hB && wdata[6]));
endmodule

bind cfgwin_top cfgwin_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc          (acc),
    .ptr_q        (ptr_q),
    .wdata        (wdata),
    .rdata        (rdata),
    .fifo_clear_o (fifo_clear_o)
);

// File: tb/cfgwin_top_test.sv
module cfgwin_top_test;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       addr = '0;
    logic             wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0]      wdata = '0;
    logic [15:0]      rdata;
    logic [1:0][7:0]  gen_cfg_o;
    logic [1:0][9:0]  ra_count_o;
    logic [1:0]       ra_enable_o, fifo_clear_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfgwin_top uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .gen_cfg_o(gen_cfg_o),
        .ra_count_o(ra_count_o), .ra_enable_o(ra_enable_o),
        .fifo_clear_o(fifo_clear_o)
    );

    // vector: {req[3:0], rd, addr[1:0], data[15:0], exp[15:0]}
    function automatic logic [38:0] mk(input int r, input bit rd, input int a,
                                       input logic [15:0] d, input logic [15:0] e);
        return {4'(r), rd, 2'(a), d, e};
    endfunction

    localparam int NV = 36;
    localparam logic [38:0] VEC [NV] = '{
        mk(1,1,1,16'h0,16'h0050),   // R1 pointer default, R8
        mk(1,1,0,16'h0,16'h01F0),   // R1 ch0 index 0
        mk(3,0,1,16'h0080,16'h0),
        mk(1,1,0,16'h0,16'h01F0),   // R3 sweep ch0
        mk(1,1,0,16'h0,16'h0001),
        mk(4,1,0,16'h0,16'h0000),   // R4 write-only
        mk(4,1,0,16'h0,16'h0000),
        mk(1,1,0,16'h0,16'h03F6),
        mk(1,1,0,16'h0,16'h00F5),
        mk(1,1,0,16'h0,16'h00DE),
        mk(3,1,0,16'h0,16'h01F0),   // R3 wrap 6 -> 0
        mk(2,0,1,16'h0088,16'h0),
        mk(1,1,0,16'h0,16'h0170),   // R1/R2 ch1 bank
        mk(1,1,0,16'h0,16'h0001),
        mk(4,1,0,16'h0,16'h0000),
        mk(4,1,0,16'h0,16'h0000),
        mk(1,1,0,16'h0,16'h0376),
        mk(1,1,0,16'h0,16'h00F5),
        mk(1,1,0,16'h0,16'h00DE),
        mk(6,0,1,16'h000D,16'h0),
        mk(6,0,0,16'hAB12,16'h0),
        mk(6,1,0,16'h0,16'h0012),   // R6 low byte only
        mk(3,1,0,16'h0,16'h0012),   // R3 no increment
        mk(6,0,1,16'h0000,16'h0),
        mk(6,0,0,16'hBEEF,16'h0),
        mk(6,1,0,16'h0,16'hBEEF),   // R6 full word
        mk(2,0,1,16'h0008,16'h0),
        mk(2,1,0,16'h0,16'h0170),   // R2 ch1 untouched
        mk(7,0,1,16'h0007,16'h0),
        mk(7,0,0,16'h1234,16'h0),
        mk(7,1,0,16'h0,16'h0000),   // R7 index 7
        mk(3,0,1,16'h0087,16'h0),
        mk(7,1,0,16'h0,16'h0000),
        mk(3,1,1,16'h0,16'h0080),   // R3 7 -> 0
        mk(8,0,1,16'h00FF,16'h0),
        mk(8,1,1,16'h0,16'h00DF)    // R8 bit 5 hidden
    };

    task automatic check(input int r, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic acc(input bit w, input bit r, input int a, input logic [15:0] d);
        @(negedge clk);
        addr = 2'(a); wr_en = w; rd_en = r; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, rdata, 16'h0);                          // R1
        check(1, {8'h0, gen_cfg_o[0]}, 16'h0001);
        check(1, {6'h0, ra_count_o[0]}, 16'h0);
        check(1, {14'h0, fifo_clear_o}, 16'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [38:0] v = VEC[i];
            acc(!v[34], v[34], int'(v[33:32]), v[31:16]);
            if (v[34]) check(int'(v[38:35]), rdata, v[15:0]);
        end
        // R4 read-ahead count assembly
        acc(1, 0, 1, 16'h0002); acc(1, 0, 0, 16'h00AB);
        acc(1, 0, 1, 16'h0003); acc(1, 0, 0, 16'h0083);
        check(4, {6'h0, ra_count_o[0]}, 16'h03AB);
        check(4, {15'h0, ra_enable_o[0]}, 16'h1);
        check(5, {14'h0, fifo_clear_o}, 16'h0);
        acc(0, 1, 0, 16'h0);
        check(4, rdata, 16'h0);
        // R5 strobe: write then sample
        @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 16'h0042;
        @(negedge clk); wr_en = 1'b0;
        check(5, {14'h0, fifo_clear_o}, 16'h0001);
        @(negedge clk);
        check(5, {14'h0, fifo_clear_o}, 16'h0000);
        check(4, {6'h0, ra_count_o[0]}, 16'h02AB);
        check(4, {15'h0, ra_enable_o[0]}, 16'h0);
        check(2, {6'h0, ra_count_o[1]}, 16'h0);
        // R6 general config byte
        acc(1, 0, 1, 16'h0001); acc(1, 0, 0, 16'hFF83);
        check(6, {8'h0, gen_cfg_o[0]}, 16'h0083);
        check(6, {8'h0, gen_cfg_o[1]}, 16'h0001);
        acc(0, 1, 0, 16'h0);
        check(6, rdata, 16'h0083);
        // R9 hold and unused offsets
        @(negedge clk);
        check(9, rdata, 16'h0083);
        acc(0, 1, 2, 16'h0);
        check(9, rdata, 16'h0);
        acc(1, 0, 3, 16'hFFFF);
        acc(0, 1, 1, 16'h0);
        check(9, rdata, 16'h0001);
        // R10 write wins over read
        acc(1, 1, 1, 16'h0005);
        check(10, rdata, 16'h0001);
        acc(0, 1, 1, 16'h0);
        check(10, rdata, 16'h0005);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule